// File: doc/BRIEF.md
# PCI Function Power-State Gating Controller

This block tracks the power-management state of a single PCI function (D0, D1, D2 or D3hot) as configuration software writes it. From that state it selects the operating mode of the attached core and gates what the function may present to the bus. That gating covers the command-register enables, the interrupt request and the bus output-enable. In the deepest retained state it also holds a soft reset on the core.

In D1 the core dozes and bus-reset events are dropped. In D2 the core sleeps, and the five bus-facing command enables are forced off at the outputs while the stored command value is kept. In D2 core and DMA interrupts are recorded but held back. On exit to D1 or D0 the stored command value reappears and any held interrupt is raised. D3hot wipes the stored command value and every pending interrupt, and keeps soft reset asserted while the state lasts. A write of D0 leaves D3hot. Recovery from a power-off state goes through the hardware reset input.

Top module: `pm_gate_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns after that edge to D0 with `cmd_out`=0, `irq_req`=0, `soft_rst`=0, `bus_oe`=1 and `core_mode`=00.
- R2: A write on `pm_wr` loads the 2-bit state code (00=D0, 01=D1, 10=D2, 11=D3hot), and `pm_state_rd` shows the last written code from the next cycle.
- R3: `core_mode` reads 00 (normal) in D0, 01 (snooze) in D1, and 10 (coma) in D2 and D3hot.
- R4: In D0 and D1 a command write is stored and appears unchanged on `cmd_out` from the next cycle.
- R5: In D2 the I/O enable (bit 0), memory enable (bit 1), bus master (bit 2), parity error response (bit 6) and SERR enable (bit 8) read 0 on `cmd_out`. All other stored bits pass through.
- R6: A command write made in D2 updates the stored value. After a move from D2 to D1 or D0, `cmd_out` shows the full stored value.
- R7: In D3hot `cmd_out` is 0, the stored value is cleared and command writes are ignored, so `cmd_out` reads 0 after a return to D0.
- R8: Interrupt events set sticky pending bits (bit 0 core, bit 1 DMA, bit 2 bus reset). `irq_clr[i]` clears bit i, but a set in the same cycle wins. In D0 and D1, `irq_req` is the OR of the pending bits.
- R9: A bus-reset event arriving outside D0 is discarded and never raises `irq_req`. Core and DMA events still raise it in D1.
- R10: In D2 `irq_req` is 0. Core and DMA events are recorded, and `irq_req` rises on exit to D1 or D0 if any are pending.
- R11: In D3hot `soft_rst` is 1 and `bus_oe` is 0 on every cycle. All pending bits are cleared and new events are ignored, so `irq_req` stays 0 after a return to D0.
- R12: The hardware reset brings the block back to the R1 state from any power state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| pm_wr | input | 1 | Write strobe for the power-state field |
| pm_wdata | input | 2 | Power-state code to write |
| cmd_wr | input | 1 | Write strobe for the command register |
| cmd_wdata | input | 16 | Command value to write |
| evt_core | input | 1 | Core interrupt event pulse |
| evt_dma | input | 1 | DMA interrupt event pulse |
| evt_busrst | input | 1 | Bus-reset event pulse |
| irq_clr | input | 3 | Per-source pending clear (bit 0 core, 1 DMA, 2 bus reset) |
| pm_state_rd | output | 2 | Current power-state code |
| cmd_out | output | 16 | Effective command register after gating |
| core_mode | output | 2 | Core mode: 00 normal, 01 snooze, 10 coma |
| irq_req | output | 1 | Interrupt request |
| soft_rst | output | 1 | Soft reset to the core |
| bus_oe | output | 1 | Bus output-enable; low means tri-stated |

## Verification
The hardest situation to reach is an interrupt that is recorded in D2 while it is invisible, and then replayed on exit. It has to be told apart from a bus-reset event that was silently dropped in the same stay. The stimulus enters D2 with a command value whose gated and ungated bits differ. It then fires a core event and a bus-reset event, and rewrites the command while still in D2. After leaving to D1, it checks that the interrupt appears along with the rewritten command. Finally it clears the core bit to show that nothing from the bus-reset event was kept. A second path puts an event pending in D0 and a command write inside D3hot, to show that both are gone after the return.

// File: rtl/pm_gate_pkg.sv
// Shared types and source indices for the power-state gating controller.
// Assumes a 2-bit state encoding that software writes directly.
package pm_gate_pkg;
    typedef enum logic [1:0] {
        PS_D0    = 2'b00,
        PS_D1    = 2'b01,
        PS_D2    = 2'b10,
        PS_D3HOT = 2'b11
    } pstate_t;

    typedef enum logic [1:0] {
        MODE_RUN  = 2'b00,
        MODE_DOZE = 2'b01,
        MODE_DEEP = 2'b10
    } core_mode_t;

    localparam int SRC_CORE   = 0;
    localparam int SRC_DMA    = 1;
    localparam int SRC_BUSRST = 2;
    localparam int NUM_SRC    = 3;
endpackage

// File: rtl/pm_state_reg.sv
// Holds the written power state and derives the core mode and the soft reset.
// Assumes writes take effect at the clock edge where pm_wr is sampled.
module pm_state_reg
    import pm_gate_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pm_wr,
    input  logic [1:0] pm_wdata,
    output pstate_t    pstate,
    output core_mode_t core_mode,
    output logic       soft_rst
);
    pstate_t state_q;

    // Load the power state on a write; hardware reset forces D0.
    always_ff @(posedge clk) begin
        if (!rst_n)     state_q <= PS_D0;
        else if (pm_wr) state_q <= pstate_t'(pm_wdata);
    end

    // Map the state onto the core operating mode.
    always_comb begin
        unique case (state_q)
            PS_D0:   core_mode = MODE_RUN;
            PS_D1:   core_mode = MODE_DOZE;
            default: core_mode = MODE_DEEP;
        endcase
    end

    assign pstate   = state_q;
    assign soft_rst = (state_q == PS_D3HOT);

    // A write of D3hot must put the soft reset up on the next cycle.
    assert_d3_srst_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_wr && pm_wdata == 2'b11) |=> soft_rst);
endmodule

// File: rtl/pm_cmd_keeper.sv
// Stores the command register and presents its gated view for each power state.
// Assumes D3hot clears the stored value on every cycle it lasts.
module pm_cmd_keeper
    import pm_gate_pkg::*;
#(
    parameter int              CMD_W     = 16,
    parameter logic [CMD_W-1:0] GATE_MASK = 16'h0147
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pstate_t          pstate,
    input  logic             cmd_wr,
    input  logic [CMD_W-1:0] cmd_wdata,
    output logic [CMD_W-1:0] cmd_out
);
    logic [CMD_W-1:0] cmd_q;

    // Keep the stored command; D3hot wipes it and refuses writes.
    always_ff @(posedge clk) begin
        if (!rst_n)                   cmd_q <= '0;
        else if (pstate == PS_D3HOT)  cmd_q <= '0;
        else if (cmd_wr)              cmd_q <= cmd_wdata;
    end

    // Present the stored value with the state's suppression applied.
    always_comb begin
        unique case (pstate)
            PS_D2:    cmd_out = cmd_q & ~GATE_MASK;
            PS_D3HOT: cmd_out = '0;
            default:  cmd_out = cmd_q;
        endcase
    end

    // In D2 the saved value survives untouched unless software writes it.
    assert_d2_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate == PS_D2 && !cmd_wr) |=> $stable(cmd_q));

    // A cycle spent in D3hot leaves nothing stored.
    assert_d3_wipe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate == PS_D3HOT) |=> (cmd_q == '0));
endmodule

// File: rtl/pm_irq_keeper.sv
// Records interrupt events per source and raises the request when the state allows.
// Assumes events are single-cycle pulses and a set wins over a clear in one cycle.
module pm_irq_keeper
    import pm_gate_pkg::*;
#(
    parameter int N_SRC = NUM_SRC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pstate_t          pstate,
    input  logic [N_SRC-1:0] evt,
    input  logic [N_SRC-1:0] clr,
    output logic             irq_req
);
    logic [N_SRC-1:0] pend_q;

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        logic accept;
        logic bit_q;

        if (i == SRC_BUSRST) begin : g_br
            assign accept = (pstate == PS_D0);
        end else begin : g_std
            assign accept = (pstate != PS_D3HOT);
        end

        // Sticky pending bit; D3hot clears it, a new event outranks a clear.
        always_ff @(posedge clk) begin
            if (!rst_n)                  bit_q <= 1'b0;
            else if (pstate == PS_D3HOT) bit_q <= 1'b0;
            else if (evt[i] && accept)   bit_q <= 1'b1;
            else if (clr[i])             bit_q <= 1'b0;
        end

        assign pend_q[i] = bit_q;
    end

    assign irq_req = ((pstate == PS_D0) || (pstate == PS_D1)) && (|pend_q);

    // A bus-reset pending bit can only come from an event seen in D0.
    assert_busrst_d0_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q[SRC_BUSRST]) |-> ($past(pstate) == PS_D0));

    // Soft reset leaves no pending interrupt behind.
    assert_d3_flush_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate == PS_D3HOT) |=> (pend_q == '0));
endmodule

// File: rtl/pm_gate_ctrl.sv
// Top of the power-state gating controller: state, command gating and interrupt hold.
// Assumes a single function and software-driven state changes only.
module pm_gate_ctrl
    import pm_gate_pkg::*;
#(
    parameter int              CMD_W     = 16,
    parameter logic [CMD_W-1:0] GATE_MASK = 16'h0147
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pm_wr,
    input  logic [1:0]       pm_wdata,
    input  logic             cmd_wr,
    input  logic [CMD_W-1:0] cmd_wdata,
    input  logic             evt_core,
    input  logic             evt_dma,
    input  logic             evt_busrst,
    input  logic [2:0]       irq_clr,
    output logic [1:0]       pm_state_rd,
    output logic [CMD_W-1:0] cmd_out,
    output logic [1:0]       core_mode,
    output logic             irq_req,
    output logic             soft_rst,
    output logic             bus_oe
);
    pstate_t          pstate;
    core_mode_t       mode;
    logic [NUM_SRC-1:0] evt_vec;

    assign evt_vec = {evt_busrst, evt_dma, evt_core};

    pm_state_reg u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .pm_wr     (pm_wr),
        .pm_wdata  (pm_wdata),
        .pstate    (pstate),
        .core_mode (mode),
        .soft_rst  (soft_rst)
    );

    pm_cmd_keeper #(.CMD_W(CMD_W), .GATE_MASK(GATE_MASK)) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .pstate    (pstate),
        .cmd_wr    (cmd_wr),
        .cmd_wdata (cmd_wdata),
        .cmd_out   (cmd_out)
    );

    pm_irq_keeper #(.N_SRC(NUM_SRC)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .pstate  (pstate),
        .evt     (evt_vec),
        .clr     (irq_clr),
        .irq_req (irq_req)
    );

    assign pm_state_rd = pstate;
    assign core_mode   = mode;
    assign bus_oe      = ~soft_rst;

    // Coma mode never shows a bus-facing enable.
    assert_coma_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (core_mode == MODE_DEEP) |-> ((cmd_out & GATE_MASK) == '0));

    // While soft reset is held, the command view and the request are silent.
    assert_srst_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> (cmd_out == '0 && !irq_req));
endmodule

// File: tb/tb_pm_gate_ctrl.sv
// Scoreboard bench: the driver models the requirements and queues expectations,
// the monitor pops one per cycle at the falling edge and compares all outputs.
module tb_pm_gate_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pm_wr = 1'b0;
    logic [1:0]  pm_wdata = '0;
    logic        cmd_wr = 1'b0;
    logic [15:0] cmd_wdata = '0;
    logic        evt_core = 1'b0, evt_dma = 1'b0, evt_busrst = 1'b0;
    logic [2:0]  irq_clr = '0;
    logic [1:0]  pm_state_rd;
    logic [15:0] cmd_out;
    logic [1:0]  core_mode;
    logic        irq_req, soft_rst, bus_oe;

    always #2 clk = ~clk;

    pm_gate_ctrl dut (
        .clk(clk), .rst_n(rst_n), .pm_wr(pm_wr), .pm_wdata(pm_wdata),
        .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .evt_core(evt_core),
        .evt_dma(evt_dma), .evt_busrst(evt_busrst), .irq_clr(irq_clr),
        .pm_state_rd(pm_state_rd), .cmd_out(cmd_out), .core_mode(core_mode),
        .irq_req(irq_req), .soft_rst(soft_rst), .bus_oe(bus_oe)
    );

    typedef struct {
        string       tag;
        logic [1:0]  ps;
        logic [15:0] cmd;
        logic        irq;
        logic [1:0]  mode;
        logic        srst;
        logic        oe;
    } exp_t;

    exp_t sbq[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 0;

    logic [1:0]  m_ps   = 2'b00;
    logic [15:0] m_cmd  = '0;
    logic [2:0]  m_pend = '0;
    localparam logic [15:0] MASK = 16'h0147;

    // Drive one cycle of stimulus, advance the model and queue the expectation.
    task automatic step(string tag, bit rn, bit pw, logic [1:0] pd,
                        bit cw, logic [15:0] cd, logic [2:0] ev, logic [2:0] clr);
        exp_t e;
        @(negedge clk);
        rst_n = rn; pm_wr = pw; pm_wdata = pd; cmd_wr = cw; cmd_wdata = cd;
        {evt_busrst, evt_dma, evt_core} = ev; irq_clr = clr;
        @(posedge clk);
        if (!rn) begin
            m_ps = 2'b00; m_cmd = '0; m_pend = '0;
        end else begin
            if (m_ps == 2'b11) begin
                m_cmd = '0; m_pend = '0;
            end else begin
                if (cw) m_cmd = cd;
                m_pend = (m_pend & ~clr) | (ev & {m_ps == 2'b00, 1'b1, 1'b1});
            end
            if (pw) m_ps = pd;
        end
        e.tag  = tag;
        e.ps   = m_ps;
        e.cmd  = (m_ps == 2'b11) ? 16'h0 : (m_ps == 2'b10) ? (m_cmd & ~MASK) : m_cmd;
        e.irq  = (m_ps < 2'b10) && (|m_pend);
        e.mode = (m_ps == 2'b00) ? 2'b00 : (m_ps == 2'b01) ? 2'b01 : 2'b10;
        e.srst = (m_ps == 2'b11);
        e.oe   = !e.srst;
        #1 sbq.push_back(e);
    endtask

    task automatic idle(string tag);
        step(tag, 1, 0, 2'b00, 0, 16'h0, 3'b000, 3'b000);
    endtask

    // Monitor: compare the oldest expectation with the outputs at the falling edge.
    always @(negedge clk) begin
        if (sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            n_cmp++;
            if (pm_state_rd !== e.ps || cmd_out !== e.cmd || irq_req !== e.irq ||
                core_mode !== e.mode || soft_rst !== e.srst || bus_oe !== e.oe) begin
                n_bad++;
                $display("FAIL %s: got ps=%b cmd=%h irq=%b mode=%b srst=%b oe=%b exp ps=%b cmd=%h irq=%b mode=%b srst=%b oe=%b",
                         e.tag, pm_state_rd, cmd_out, irq_req, core_mode, soft_rst, bus_oe,
                         e.ps, e.cmd, e.irq, e.mode, e.srst, e.oe);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        step("R1", 0, 0, 2'b00, 0, 16'h0, 3'b000, 3'b000);
        step("R1", 0, 0, 2'b00, 0, 16'h0, 3'b000, 3'b000);
        idle("R1");
        // R4: command write in D0
        step("R4", 1, 0, 2'b00, 1, 16'h0147, 3'b000, 3'b000);
        idle("R4");
        // R8: core event, clear, set-wins-over-clear on DMA
        step("R8", 1, 0, 2'b00, 0, 16'h0, 3'b001, 3'b000);
        step("R8", 1, 0, 2'b00, 0, 16'h0, 3'b000, 3'b001);
        step("R8", 1, 0, 2'b00, 0, 16'h0, 3'b010, 3'b010);
        step("R8", 1, 0, 2'b00, 0, 16'h0, 3'b000, 3'b010);
        // R2/R3: enter D1
        step("R3", 1, 1, 2'b01, 0, 16'h0, 3'b000, 3'b000);
        // R9: bus reset dropped in D1, core event still raises
        step("R9", 1, 0, 2'b00, 0, 16'h0, 3'b100, 3'b000);
        idle("R9");
        step("R9", 1, 0, 2'b00, 0, 16'h0, 3'b001, 3'b000);
        step("R9", 1, 0, 2'b00, 0, 16'h0, 3'b000, 3'b001);
        step("R4", 1, 0, 2'b00, 1, 16'h0BEE, 3'b000, 3'b000);
        // R2: back to D0, bus reset now counts (R8)
        step("R2", 1, 1, 2'b00, 0, 16'h0, 3'b000, 3'b000);
        step("R8", 1, 0, 2'b00, 0, 16'h0, 3'b100, 3'b000);
        step("R8", 1, 0, 2'b00, 0, 16'h0, 3'b000, 3'b100);
        // R5: D2 gating of 0x01FF
        step("R5", 1, 0, 2'b00, 1, 16'h01FF, 3'b000, 3'b000);
        step("R5", 1, 1, 2'b10, 0, 16'h0, 3'b000, 3'b000);
        // R10: core and bus reset events held / dropped in D2
        step("R10", 1, 0, 2'b00, 0, 16'h0, 3'b001, 3'b000);
        step("R10", 1, 0, 2'b00, 0, 16'h0, 3'b100, 3'b000);
        // R6: rewrite command inside D2, then exit to D1
        step("R6", 1, 0, 2'b00, 1, 16'h0036, 3'b000, 3'b000);
        step("R6", 1, 1, 2'b01, 0, 16'h0, 3'b000, 3'b000);
        step("R10", 1, 0, 2'b00, 0, 16'h0, 3'b000, 3'b001);
        idle("R10");
        // R11/R7: pending in D0, then D3hot
        step("R2", 1, 1, 2'b00, 1, 16'hFFFF, 3'b000, 3'b000);
        step("R11", 1, 0, 2'b00, 0, 16'h0, 3'b001, 3'b000);
        step("R11", 1, 1, 2'b11, 0, 16'h0, 3'b000, 3'b000);
        idle("R11");
        step("R7", 1, 0, 2'b00, 1, 16'h1234, 3'b000, 3'b000);
        step("R11", 1, 0, 2'b00, 0, 16'h0, 3'b011, 3'b000);
        step("R7", 1, 1, 2'b00, 0, 16'h0, 3'b000, 3'b000);
        idle("R11");
        // R12: hardware reset from D2 with a stored command
        step("R12", 1, 0, 2'b00, 1, 16'h0147, 3'b000, 3'b000);
        step("R12", 1, 1, 2'b10, 0, 16'h0, 3'b001, 3'b000);
        step("R12", 0, 0, 2'b00, 0, 16'h0, 3'b000, 3'b000);
        idle("R12");
        repeat (3) @(negedge clk);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule